// File: doc/BRIEF.md
# Host Bridge Address Decoder

This block sits between a 32-bit CPU bus and a PCI host bridge. Each request arrives with an address, an access size, a write flag and the level of a window-mode pin. The block picks one bridge target: I/O space, configuration space, interrupt acknowledge or PCI memory. It computes the address as that target sees it, and raises an unmapped flag when no window matches. The host then answers reads of an unmapped access with all ones and drops its writes. The decode is registered once. Requests and results both move over valid/ready handshakes.

A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The result is presented on the next cycle with `out_valid` high. It stays on the pins, unchanged, until a clock edge where `out_ready` is high. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input without losing anything.

Two small combinational paths sit beside the decoder. One translates bus-master (PCI-side) addresses into system-memory addresses. The other routes a PCI interrupt pin of a device to one of two interrupt lines.

Top module: `hb_addr_decoder`

## Requirements
- R1: With `io_sparse` low, an address in 0x8000_0000 to 0x807F_FFFF selects I/O (`out_sel` bit 0), and `out_addr` is the offset from 0x8000_0000.
- R2: With `io_sparse` high at the time a request is accepted, an I/O-window request yields `out_addr` built as follows: offset bits [4:0] stay in bits [4:0], offset bits [26:12] are moved to bits [19:5], and all other bits are zero.
- R3: An address in 0x8080_0000 to 0x80BF_FFFF selects configuration (`out_sel` bit 1). The slot index is the position (0 to 10) of the lowest set bit among offset bits 11 to 21, or 11 if none of them is set. `out_addr` is the slot index times 2048 plus offset bits [10:0].
- R4: A one-byte read at 0xBFFF_FFF0 selects interrupt acknowledge (`out_sel` bit 2) with `out_addr` zero. A write, or a wider access, at that address selects nothing and is flagged unmapped.
- R5: An address in 0xC000_0000 to 0xFEFF_FFFF selects PCI memory (`out_sel` bit 3), with `out_addr` equal to the address minus 0xC000_0000.
- R6: Any other address, and any request whose `req_size` code is 3, gives `out_sel` zero, `out_unmapped` high and `out_addr` zero. `req_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes.
- R7: While `out_valid` is high, at most one `out_sel` bit is set, and `out_unmapped` is high exactly when none is set. `out_write` and `out_size` repeat the accepted request.
- R8: An accepted request gives `out_valid` high on the next cycle. `req_ready` equals `!out_valid || out_ready`. A result that is not taken holds its values. Results leave in the order their requests were accepted.
- R9: A bus-master address at or above 0x8000_0000 raises `bm_to_sys` and yields `bm_xaddr` equal to the address minus 0x8000_0000. A lower address leaves `bm_to_sys` low and passes through unchanged as a PCI-memory alias.
- R10: `irq_line` is (`irq_pin` + `irq_dev`) modulo 2, where `irq_pin` 0 to 3 names pins A to D.
- R11: After reset, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_sparse | input | 1 | I/O window mode level, sampled with each request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | CPU address |
| req_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2: 4 B, 3: illegal) |
| req_write | input | 1 | Write when high |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Result taken |
| out_sel | output | 4 | One-hot target: 0 I/O, 1 config, 2 int-ack, 3 memory |
| out_addr | output | 32 | Translated target address |
| out_unmapped | output | 1 | No window matched |
| out_write | output | 1 | Write flag of the result |
| out_size | output | 2 | Size code of the result |
| bm_addr | input | 32 | Bus-master PCI address |
| bm_to_sys | output | 1 | Bus-master address goes to system memory |
| bm_xaddr | output | 32 | Translated bus-master address |
| irq_pin | input | 2 | PCI interrupt pin (0 to 3) |
| irq_dev | input | 5 | PCI device number |
| irq_line | output | 1 | Selected interrupt line |

## Verification
The assertions check the following on every cycle: the target selects are one-hot or zero and agree with the unmapped flag; an interrupt-acknowledge result is always a one-byte read; an accepted request always shows up one cycle later; and a stalled result does not move. The bus-master translation is also held to its two ranges at all times. The exact arithmetic of each window can only be shown by the bench's scenarios. This covers the sparse packing, the lowest-bit slot index (including the no-bit and multiple-bit cases), the window edges and the illegal size code. The same holds for keeping order under a stalling consumer and for the effect of changing the mode pin between requests.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int ADDR_W = 32;

  localparam logic [ADDR_W-1:0] IO_BASE   = 32'h8000_0000;
  localparam int                IO_LG     = 23;
  localparam logic [ADDR_W-1:0] CFG_BASE  = 32'h8080_0000;
  localparam int                CFG_LG    = 22;
  localparam int                CFG_LOW   = 11;
  localparam logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0;
  localparam logic [ADDR_W-1:0] MEM_BASE  = 32'hC000_0000;
  localparam logic [ADDR_W-1:0] MEM_SIZE  = 32'h3F00_0000;
  localparam logic [ADDR_W-1:0] BM_SYS    = 32'h8000_0000;

  localparam int N_TGT    = 4;
  localparam int TGT_IO   = 0;
  localparam int TGT_CFG  = 1;
  localparam int TGT_IACK = 2;
  localparam int TGT_MEM  = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [N_TGT-1:0]  sel;
    logic              unmapped;
    logic [ADDR_W-1:0] addr;
  } dec_res_t;
endpackage

// File: rtl/hb_cfg_index.sv
module hb_cfg_index #(
  parameter int SLOTS = 11,
  parameter int LOW   = 11,
  localparam int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic [LOW+SLOTS-1:0] off,
  output logic [IDX_W-1:0]     idx
);
  // Scan from the top down so the lowest set bit wins.
  always_comb begin
    idx = IDX_W'(SLOTS);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (off[LOW+i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/hb_win_decode.sv
module hb_win_decode
  import hb_pkg::*;
#(
  parameter int CFG_SLOTS = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic              sparse,
  output dec_res_t          res
);
  localparam int CFG_OFF_W = CFG_LOW + CFG_SLOTS;
  localparam int IDX_W     = $clog2(CFG_SLOTS + 1);

  acc_size_e         sz;
  logic              size_ok, in_io, in_cfg, in_iack, in_mem;
  logic [ADDR_W-1:0] io_off, io_sparse_addr, cfg_addr, mem_off;
  logic [IDX_W-1:0]  slot;

  assign sz      = acc_size_e'(size);
  assign size_ok = (sz != SZ_BAD);

  assign in_io   = addr[ADDR_W-1:IO_LG]  == IO_BASE[ADDR_W-1:IO_LG];
  assign in_cfg  = addr[ADDR_W-1:CFG_LG] == CFG_BASE[ADDR_W-1:CFG_LG];
  assign in_iack = (addr == IACK_ADDR) && (sz == SZ_BYTE) && !wr;
  assign in_mem  = (addr >= MEM_BASE) && (addr < MEM_BASE + MEM_SIZE);

  assign io_off  = {{(ADDR_W-IO_LG){1'b0}}, addr[IO_LG-1:0]};
  assign mem_off = addr - MEM_BASE;

  // Sparse packing: keep the low five bits, pull page bits down by seven.
  assign io_sparse_addr = ((io_off & 32'h07FF_F000) >> 7) | (io_off & 32'h0000_001F);

  hb_cfg_index #(.SLOTS(CFG_SLOTS), .LOW(CFG_LOW)) u_idx (
    .off (addr[CFG_OFF_W-1:0]),
    .idx (slot)
  );

  assign cfg_addr = ({{(ADDR_W-IDX_W){1'b0}}, slot} << CFG_LOW)
                  | {{(ADDR_W-CFG_LOW){1'b0}}, addr[CFG_LOW-1:0]};

  always_comb begin
    res          = '0;
    res.unmapped = 1'b1;
    if (size_ok) begin
      if (in_io) begin
        res.sel[TGT_IO] = 1'b1;
        res.addr        = sparse ? io_sparse_addr : io_off;
      end else if (in_cfg) begin
        res.sel[TGT_CFG] = 1'b1;
        res.addr         = cfg_addr;
      end else if (in_iack) begin
        res.sel[TGT_IACK] = 1'b1;
      end else if (in_mem) begin
        res.sel[TGT_MEM] = 1'b1;
        res.addr         = mem_off;
      end
      res.unmapped = (res.sel == '0);
    end
  end
endmodule

// File: rtl/hb_bm_xlate.sv
module hb_bm_xlate
  import hb_pkg::*;
(
  input  logic [ADDR_W-1:0] pci_addr,
  output logic              to_sys,
  output logic [ADDR_W-1:0] xaddr
);
  assign to_sys = (pci_addr >= BM_SYS);
  assign xaddr  = to_sys ? (pci_addr - BM_SYS) : pci_addr;
endmodule

// File: rtl/hb_irq_route.sv
module hb_irq_route #(
  parameter int PIN_W = 2,
  parameter int DEV_W = 5,
  localparam int SW   = ((PIN_W > DEV_W) ? PIN_W : DEV_W) + 1
) (
  input  logic [PIN_W-1:0] pin,
  input  logic [DEV_W-1:0] dev,
  output logic             line
);
  assign line = ((SW'(pin) + SW'(dev)) % SW'(2)) != '0;
endmodule

// File: rtl/hb_addr_decoder.sv
module hb_addr_decoder
  import hb_pkg::*;
#(
  parameter int CFG_SLOTS = 11,
  parameter int PIN_W     = 2,
  parameter int DEV_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_sparse,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N_TGT-1:0]     out_sel,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_unmapped,
  output logic                 out_write,
  output logic [1:0]           out_size,
  input  logic [ADDR_W-1:0]    bm_addr,
  output logic                 bm_to_sys,
  output logic [ADDR_W-1:0]    bm_xaddr,
  input  logic [PIN_W-1:0]     irq_pin,
  input  logic [DEV_W-1:0]     irq_dev,
  output logic                 irq_line
);
  dec_res_t   dec_next, dec_q;
  logic       accept;
  logic       wr_q;
  logic [1:0] size_q;

  hb_win_decode #(.CFG_SLOTS(CFG_SLOTS)) u_dec (
    .addr   (req_addr),
    .size   (req_size),
    .wr     (req_write),
    .sparse (io_sparse),
    .res    (dec_next)
  );

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_q     <= '0;
      wr_q      <= 1'b0;
      size_q    <= 2'd0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        dec_q     <= dec_next;
        wr_q      <= req_write;
        size_q    <= req_size;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_sel      = dec_q.sel;
  assign out_addr     = dec_q.addr;
  assign out_unmapped = dec_q.unmapped;
  assign out_write    = wr_q;
  assign out_size     = size_q;

  hb_bm_xlate u_bm (
    .pci_addr (bm_addr),
    .to_sys   (bm_to_sys),
    .xaddr    (bm_xaddr)
  );

  hb_irq_route #(.PIN_W(PIN_W), .DEV_W(DEV_W)) u_irq (
    .pin  (irq_pin),
    .dev  (irq_dev),
    .line (irq_line)
  );

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_sel));
  assert_unmapped_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_unmapped == (out_sel == '0)));
  assert_iack_byte_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sel[TGT_IACK]) |-> (!out_write && out_size == SZ_BYTE));
  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_sel)
                                   && $stable(out_unmapped)));
  assert_bm_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bm_to_sys |-> (bm_xaddr < BM_SYS));
  assert_bm_alias_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_to_sys |-> (bm_xaddr == bm_addr));
endmodule

// File: tb/sim_hb_addr_decoder.sv
`timescale 1ns/1ps
module sim_hb_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sparse = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_sel;
  logic [31:0] out_addr;
  logic        out_unmapped;
  logic        out_write;
  logic [1:0]  out_size;
  logic [31:0] bm_addr = '0;
  logic        bm_to_sys;
  logic [31:0] bm_xaddr;
  logic [1:0]  irq_pin = '0;
  logic [4:0]  irq_dev = '0;
  logic        irq_line;

  always #4 clk = ~clk;

  hb_addr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .io_sparse(io_sparse),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_addr(out_addr), .out_unmapped(out_unmapped), .out_write(out_write),
    .out_size(out_size), .bm_addr(bm_addr), .bm_to_sys(bm_to_sys),
    .bm_xaddr(bm_xaddr), .irq_pin(irq_pin), .irq_dev(irq_dev), .irq_line(irq_line)
  );

  typedef struct {
    logic [3:0]  sel;
    logic        unm;
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  size;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   stall_on = 1'b0;
  bit   finished = 1'b0;

  function automatic exp_t model(logic [31:0] a, logic [1:0] sz, logic wr, logic sp, string r);
    exp_t e;
    logic [31:0] off;
    int idx;
    e.sel = 4'b0000; e.unm = 1'b1; e.addr = 32'h0; e.wr = wr; e.size = sz; e.req = r;
    if (sz == 2'd3) return e;
    if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
      off = a - 32'h8000_0000;
      e.sel = 4'b0001; e.unm = 1'b0;
      e.addr = sp ? {12'b0, off[26:12], off[4:0]} : off;
    end else if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      off = a - 32'h8080_0000;
      idx = 11;
      for (int i = 10; i >= 0; i--) if (off[11+i]) idx = i;
      e.sel = 4'b0010; e.unm = 1'b0;
      e.addr = idx * 2048 + {21'b0, off[10:0]};
    end else if (a == 32'hBFFF_FFF0 && sz == 2'd0 && !wr) begin
      e.sel = 4'b0100; e.unm = 1'b0;
    end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
      e.sel = 4'b1000; e.unm = 1'b0;
      e.addr = a - 32'hC000_0000;
    end
    return e;
  endfunction

  task automatic check(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic [1:0] sz, logic wr, logic sp, string r);
    bit done = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; io_sparse = sp;
    while (!done) begin
      #2;
      if (req_ready) begin
        sb.push_back(model(a, sz, wr, sp, r));
        @(posedge clk);
        done = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: sets the consumer's readiness, then compares any result taken.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_on ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected result", {28'b0, out_sel}, 64'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_sel == e.sel, e.req, "out_sel", {60'b0, out_sel}, {60'b0, e.sel});
          check(out_unmapped == e.unm, e.req, "out_unmapped", {63'b0, out_unmapped}, {63'b0, e.unm});
          check(out_addr == e.addr, e.req, "out_addr", {32'b0, out_addr}, {32'b0, e.addr});
          check(out_write == e.wr && out_size == e.size, "R7", "write/size",
                {61'b0, out_write, out_size}, {61'b0, e.wr, e.size});
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R8 watchdog expired: actual %0d pending expected 0", sb.size());
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R11", "out_valid after reset", {63'b0, out_valid}, 64'h0);
    check(req_ready == 1'b1, "R11", "req_ready after reset", {63'b0, req_ready}, 64'h1);
    rst_n = 1'b1;

    // R8 latency: one request, valid one cycle later
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8000_0CF8; req_size = 2'd2; req_write = 1'b0; io_sparse = 1'b0;
    #2;
    sb.push_back(model(32'h8000_0CF8, 2'd2, 1'b0, 1'b0, "R1"));
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    check(out_valid == 1'b1, "R8", "out_valid one cycle after accept", {63'b0, out_valid}, 64'h1);

    // R1 contiguous I/O
    send(32'h8000_0CFC, 2'd0, 1'b1, 1'b0, "R1");
    send(32'h807F_FFFF, 2'd0, 1'b0, 1'b0, "R1");
    // R2 sparse I/O, including mode flipping between requests
    send(32'h8000_1234, 2'd1, 1'b0, 1'b1, "R2");
    send(32'h807F_F01F, 2'd2, 1'b1, 1'b1, "R2");
    send(32'h8000_1234, 2'd1, 1'b0, 1'b0, "R1");
    // R3 configuration slots
    send(32'h8080_1004, 2'd2, 1'b0, 1'b0, "R3");
    send(32'h80A0_0044, 2'd2, 1'b1, 1'b0, "R3");
    send(32'h8080_0010, 2'd0, 1'b0, 1'b0, "R3");
    send(32'h8080_6000, 2'd2, 1'b0, 1'b0, "R3");
    send(32'h8080_0FFF, 2'd0, 1'b0, 1'b0, "R3");
    // R4 interrupt acknowledge
    send(32'hBFFF_FFF0, 2'd0, 1'b0, 1'b0, "R4");
    send(32'hBFFF_FFF0, 2'd0, 1'b1, 1'b0, "R4");
    send(32'hBFFF_FFF0, 2'd1, 1'b0, 1'b0, "R4");
    // R5 PCI memory edges
    send(32'hC000_0000, 2'd2, 1'b0, 1'b0, "R5");
    send(32'hFEFF_FFFF, 2'd0, 1'b1, 1'b0, "R5");
    // R6 unmapped cases
    send(32'hFF00_0000, 2'd2, 1'b0, 1'b0, "R6");
    send(32'h0000_1000, 2'd2, 1'b0, 1'b0, "R6");
    send(32'h80C0_0000, 2'd0, 1'b0, 1'b0, "R6");
    send(32'hBFFF_FFEF, 2'd0, 1'b0, 1'b0, "R6");
    send(32'h8000_0CF8, 2'd3, 1'b0, 1'b0, "R6");

    // R8 ordering under back-pressure
    stall_on = 1'b1;
    for (int k = 0; k < 24; k++) begin
      send(32'h8080_0800 + (32'(k) << 12), 2'(k % 3), k[0], k[1], "R8");
      send(32'hC000_0100 + 32'(k * 4), 2'd2, 1'b0, 1'b0, "R8");
    end
    for (int w = 0; w < 40 && sb.size() != 0; w++) @(negedge clk);
    stall_on = 1'b0;
    for (int w = 0; w < 20 && sb.size() != 0; w++) @(negedge clk);
    check(sb.size() == 0, "R8", "all results drained", 64'(sb.size()), 64'h0);

    // R9 bus-master translation
    begin
      logic [31:0] bv [4] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFC};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        bm_addr = bv[k];
        #1;
        check(bm_to_sys == bv[k][31], "R9", "bm_to_sys", {63'b0, bm_to_sys}, {63'b0, bv[k][31]});
        check(bm_xaddr == (bv[k][31] ? bv[k] - 32'h8000_0000 : bv[k]), "R9", "bm_xaddr",
              {32'b0, bm_xaddr}, {32'b0, (bv[k][31] ? bv[k] - 32'h8000_0000 : bv[k])});
      end
    end

    // R10 interrupt routing over all pins and some devices
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 32; d += 7) begin
        @(negedge clk);
        irq_pin = 2'(p); irq_dev = 5'(d);
        #1;
        check(irq_line == 1'((p + d) % 2), "R10", "irq_line", {63'b0, irq_line}, 64'((p + d) % 2));
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule